// File: doc/BRIEF.md
# Partition-Tagged Bandwidth Regulator and Monitor

This block sits on a memory request path. Several request sources each offer one request at a time, and every request carries a partition number, a monitor-group tag, a direction (read or write), a byte length and an address. The block keeps a credit budget for every pairing of partition and direction. A request may leave only when its own budget covers its length. When several requests are eligible, partitions that have not yet received their guaranteed share in the current refill period go first. One request per cycle passes to a single output with a valid/ready handshake.

The budgets refill on a fixed period. The amount added on each refill is programmable, and a budget saturates at twice that amount. A small set of monitors adds up the bytes of issued requests that match a programmed partition, monitor group and direction. A source that cannot tag its requests sends them untagged, and the block substitutes a programmable default partition and monitor group.

Configuration uses a write-only port with an address and data. The address is split into a two-bit region field and a slot index below it. With the default parameters the slot index is three bits wide, laid out as {partition, direction}.

Top module: `part_bw_regulator`

## Requirements
- R1: Once reset is released, every credit, refill amount, minimum and monitor count is zero, and the default tag is partition 0, group 0. A request with a nonzero length therefore does not issue.
- R2: A request is eligible only when the credit for its slot, {partition, direction}, is at least its length. Each accepted transfer takes its length away from that credit, and from no other credit.
- R3: On every PERIOD-th clock the refill amount is added to each credit. The result is capped at twice the refill amount. A write to region 0 (address {2'b00, slot}) stores the refill amount for that slot and also loads it into the slot's credit.
- R4: Read and write budgets are separate. src_write=0 selects direction 0 (read) and src_write=1 selects direction 1 (write). Using up one direction of a partition leaves the other direction eligible.
- R5: A region 1 write (address {2'b01, slot}) sets a minimum byte count for that slot. An eligible request is urgent while the bytes granted to its slot in the current period are below that minimum. Urgent requests win over non-urgent ones, and within each class the lowest source index wins.
- R6: A source with src_tagged=0 has its request issued with the default partition and group. A region 3 write sets the default: partition in wdata[PID_W-1:0], group in wdata[PID_W+PMG_W-1:PID_W].
- R7: A region 2 write at slot index m programs monitor m: partition in wdata[PID_W-1:0], group in the next PMG_W bits, direction in the bit above those. Monitor m adds the length of each accepted transfer whose partition, group and direction all match.
- R8: A monitor count holds at its all-ones value instead of wrapping.
- R9: Programming a monitor clears its count and leaves the other monitors unchanged.
- R10: At most one src_ready is high in any cycle, and only while out_ready is high. A request stalled by out_ready=0 uses no credit.
- R11: A request held for lack of credit issues after the next refill adds enough credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | NSRC | Request offered, per source |
| src_ready | output | NSRC | Request accepted, per source |
| src_tagged | input | NSRC | Source supplies its own partition and group |
| src_pid | input | NSRC*PID_W | Partition number per source |
| src_pmg | input | NSRC*PMG_W | Monitor group per source |
| src_write | input | NSRC | Direction: 1 write, 0 read |
| src_len | input | NSRC*LEN_W | Byte length per source |
| src_addr | input | NSRC*ADDR_W | Request address per source |
| out_valid | output | 1 | Granted request present |
| out_ready | input | 1 | Downstream accepts |
| out_pid | output | PID_W | Effective partition of granted request |
| out_pmg | output | PMG_W | Effective group of granted request |
| out_write | output | 1 | Direction of granted request |
| out_len | output | LEN_W | Length of granted request |
| out_addr | output | ADDR_W | Address of granted request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | {region, slot index} |
| cfg_wdata | input | CRED_W-1 | Configuration data |
| mon_count | output | NUM_MON*MON_W | Monitor byte counts, monitor m at bits m*MON_W |

## Verification
Two functions can act in the same cycle: the minimum-share priority and the lowest-index tie break. They are made to collide by offering requests from two partitions at once, where the higher-index source belongs to a partition with an unmet minimum. The bench then holds both requests for three cycles. It expects the higher-index source to win while that slot's granted bytes stay below the minimum, and expects the lower-index source to take over on the cycle the minimum is reached. A second collision is a stalled output against budget spending. The bench holds out_ready low over a granted request and then confirms that the remaining credit admits exactly one more request of the remaining size.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

    localparam int NDIR = 2;

    typedef enum logic [1:0] {
        RGN_MAX  = 2'd0,
        RGN_MIN  = 2'd1,
        RGN_MON  = 2'd2,
        RGN_DFLT = 2'd3
    } cfg_region_e;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

endpackage

// File: rtl/bwr_credit_bank.sv
module bwr_credit_bank #(
    parameter int NSLOT  = 8,
    parameter int SLOT_W = 3,
    parameter int CRED_W = 12,
    parameter int LEN_W  = 8,
    parameter int PERIOD = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_max,
    input  logic              ld_min,
    input  logic [SLOT_W-1:0] ld_slot,
    input  logic [CRED_W-2:0] ld_val,
    input  logic              fire,
    input  logic [SLOT_W-1:0] fire_slot,
    input  logic [LEN_W-1:0]  fire_len,
    output logic [CRED_W-1:0] cred   [NSLOT],
    output logic [CRED_W-1:0] used   [NSLOT],
    output logic [CRED_W-2:0] refill [NSLOT],
    output logic [CRED_W-2:0] minv   [NSLOT]
);
    localparam int TMR_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [TMR_W-1:0] tmr;
    logic             tick;

    assign tick = (tmr == TMR_W'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst)       tmr <= '0;
        else if (tick) tmr <= '0;
        else           tmr <= tmr + 1'b1;
    end

    for (genvar e = 0; e < NSLOT; e++) begin : g_slot
        logic              take;
        logic [CRED_W:0]   sum;
        logic [CRED_W:0]   cap;
        logic [CRED_W:0]   usum;
        logic [CRED_W-1:0] cnext;
        logic [CRED_W-1:0] unext;

        always_comb begin
            take = fire && (fire_slot == SLOT_W'(e));
            sum  = {1'b0, cred[e]} - (take ? (CRED_W+1)'(fire_len) : '0);
            if (tick) sum = sum + (CRED_W+1)'(refill[e]);
            cap   = {1'b0, refill[e], 1'b0};
            cnext = (sum > cap) ? cap[CRED_W-1:0] : sum[CRED_W-1:0];
            usum  = (tick ? '0 : {1'b0, used[e]}) + (take ? (CRED_W+1)'(fire_len) : '0);
            unext = usum[CRED_W] ? '1 : usum[CRED_W-1:0];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cred[e]   <= '0;
                used[e]   <= '0;
                refill[e] <= '0;
                minv[e]   <= '0;
            end else begin
                used[e] <= unext;
                if (ld_max && ld_slot == SLOT_W'(e)) begin
                    refill[e] <= ld_val;
                    cred[e]   <= CRED_W'(ld_val);
                end else begin
                    cred[e] <= cnext;
                end
                if (ld_min && ld_slot == SLOT_W'(e)) minv[e] <= ld_val;
            end
        end
    end

endmodule

// File: rtl/bwr_arbiter.sv
module bwr_arbiter #(
    parameter int NSRC   = 3,
    parameter int NSLOT  = 8,
    parameter int SLOT_W = 3,
    parameter int LEN_W  = 8,
    parameter int CRED_W = 12
) (
    input  logic [NSRC-1:0]   req,
    input  logic [SLOT_W-1:0] slot [NSRC],
    input  logic [LEN_W-1:0]  len  [NSRC],
    input  logic [CRED_W-1:0] cred [NSLOT],
    input  logic [CRED_W-1:0] used [NSLOT],
    input  logic [CRED_W-2:0] minv [NSLOT],
    output logic [NSRC-1:0]   urgent,
    output logic [NSRC-1:0]   grant,
    output logic              any
);
    logic [NSRC-1:0] elig;
    logic            hit_u;
    logic            hit_e;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            elig[i]   = req[i] && (cred[slot[i]] >= CRED_W'(len[i]));
            urgent[i] = elig[i] && (used[slot[i]] < CRED_W'(minv[slot[i]]));
        end
        grant = '0;
        hit_u = 1'b0;
        hit_e = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (urgent[i] && !hit_u) begin
                grant[i] = 1'b1;
                hit_u    = 1'b1;
            end
        end
        if (!hit_u) begin
            for (int i = 0; i < NSRC; i++) begin
                if (elig[i] && !hit_e) begin
                    grant[i] = 1'b1;
                    hit_e    = 1'b1;
                end
            end
        end
        any = |elig;
    end

endmodule

// File: rtl/bwr_monitor.sv
module bwr_monitor #(
    parameter int PID_W = 2,
    parameter int PMG_W = 2,
    parameter int LEN_W = 8,
    parameter int MON_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prog,
    input  logic [PID_W-1:0] prog_pid,
    input  logic [PMG_W-1:0] prog_pmg,
    input  logic             prog_dir,
    input  logic             fire,
    input  logic [PID_W-1:0] pid,
    input  logic [PMG_W-1:0] pmg,
    input  logic             dir,
    input  logic [LEN_W-1:0] len,
    output logic [MON_W-1:0] count
);
    logic [PID_W-1:0] m_pid;
    logic [PMG_W-1:0] m_pmg;
    logic             m_dir;
    logic [MON_W:0]   sum;
    logic             match;

    assign match = fire && pid == m_pid && pmg == m_pmg && dir == m_dir;
    assign sum   = {1'b0, count} + (MON_W+1)'(len);

    always_ff @(posedge clk) begin
        if (rst) begin
            m_pid <= '0;
            m_pmg <= '0;
            m_dir <= 1'b0;
            count <= '0;
        end else if (prog) begin
            m_pid <= prog_pid;
            m_pmg <= prog_pmg;
            m_dir <= prog_dir;
            count <= '0;
        end else if (match) begin
            count <= sum[MON_W] ? '1 : sum[MON_W-1:0];
        end
    end

endmodule

// File: rtl/part_bw_regulator.sv
module part_bw_regulator
    import bwr_pkg::*;
#(
    parameter int NSRC    = 3,
    parameter int PID_W   = 2,
    parameter int PMG_W   = 2,
    parameter int LEN_W   = 8,
    parameter int ADDR_W  = 32,
    parameter int CRED_W  = 12,
    parameter int PERIOD  = 256,
    parameter int NUM_MON = 2,
    parameter int MON_W   = 32,
    parameter int CFG_AW  = PID_W + 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NSRC-1:0]         src_valid,
    output logic [NSRC-1:0]         src_ready,
    input  logic [NSRC-1:0]         src_tagged,
    input  logic [NSRC*PID_W-1:0]   src_pid,
    input  logic [NSRC*PMG_W-1:0]   src_pmg,
    input  logic [NSRC-1:0]         src_write,
    input  logic [NSRC*LEN_W-1:0]   src_len,
    input  logic [NSRC*ADDR_W-1:0]  src_addr,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [PID_W-1:0]        out_pid,
    output logic [PMG_W-1:0]        out_pmg,
    output logic                    out_write,
    output logic [LEN_W-1:0]        out_len,
    output logic [ADDR_W-1:0]       out_addr,
    input  logic                    cfg_we,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [CRED_W-2:0]       cfg_wdata,
    output logic [NUM_MON*MON_W-1:0] mon_count
);
    localparam int NPART  = 1 << PID_W;
    localparam int NSLOT  = NPART * NDIR;
    localparam int SLOT_W = PID_W + 1;

    cfg_region_e       rgn;
    logic [SLOT_W-1:0] cidx;
    logic [PID_W-1:0]  dflt_pid;
    logic [PMG_W-1:0]  dflt_pmg;
    logic [NUM_MON-1:0] mon_clr;

    assign rgn  = cfg_region_e'(cfg_addr[SLOT_W +: 2]);
    assign cidx = cfg_addr[SLOT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            dflt_pid <= '0;
            dflt_pmg <= '0;
        end else if (cfg_we && rgn == RGN_DFLT) begin
            dflt_pid <= cfg_wdata[PID_W-1:0];
            dflt_pmg <= cfg_wdata[PID_W +: PMG_W];
        end
    end

    logic [PID_W-1:0]  eff_pid [NSRC];
    logic [PMG_W-1:0]  eff_pmg [NSRC];
    logic [SLOT_W-1:0] s_slot  [NSRC];
    logic [LEN_W-1:0]  s_len   [NSRC];

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign eff_pid[i] = src_tagged[i] ? src_pid[i*PID_W +: PID_W] : dflt_pid;
        assign eff_pmg[i] = src_tagged[i] ? src_pmg[i*PMG_W +: PMG_W] : dflt_pmg;
        assign s_slot[i]  = {eff_pid[i], src_write[i]};
        assign s_len[i]   = src_len[i*LEN_W +: LEN_W];
    end

    logic [CRED_W-1:0] bank_cred   [NSLOT];
    logic [CRED_W-1:0] bank_used   [NSLOT];
    logic [CRED_W-2:0] bank_refill [NSLOT];
    logic [CRED_W-2:0] bank_minv   [NSLOT];
    logic [NSRC-1:0]   arb_urgent;
    logic [NSRC-1:0]   arb_grant;
    logic              fire;
    logic [SLOT_W-1:0] gnt_slot;

    bwr_arbiter #(
        .NSRC(NSRC), .NSLOT(NSLOT), .SLOT_W(SLOT_W), .LEN_W(LEN_W), .CRED_W(CRED_W)
    ) i_arb (
        .req(src_valid), .slot(s_slot), .len(s_len),
        .cred(bank_cred), .used(bank_used), .minv(bank_minv),
        .urgent(arb_urgent), .grant(arb_grant), .any(out_valid)
    );

    always_comb begin
        out_pid   = '0;
        out_pmg   = '0;
        out_write = 1'b0;
        out_len   = '0;
        out_addr  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (arb_grant[i]) begin
                out_pid   = eff_pid[i];
                out_pmg   = eff_pmg[i];
                out_write = src_write[i];
                out_len   = s_len[i];
                out_addr  = src_addr[i*ADDR_W +: ADDR_W];
            end
        end
    end

    assign src_ready = arb_grant & {NSRC{out_ready}};
    assign fire      = out_valid && out_ready;
    assign gnt_slot  = {out_pid, out_write};

    bwr_credit_bank #(
        .NSLOT(NSLOT), .SLOT_W(SLOT_W), .CRED_W(CRED_W), .LEN_W(LEN_W), .PERIOD(PERIOD)
    ) i_bank (
        .clk(clk), .rst(rst),
        .ld_max(cfg_we && rgn == RGN_MAX),
        .ld_min(cfg_we && rgn == RGN_MIN),
        .ld_slot(cidx), .ld_val(cfg_wdata),
        .fire(fire), .fire_slot(gnt_slot), .fire_len(out_len),
        .cred(bank_cred), .used(bank_used), .refill(bank_refill), .minv(bank_minv)
    );

    for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
        assign mon_clr[m] = cfg_we && rgn == RGN_MON && cidx == SLOT_W'(m);

        bwr_monitor #(
            .PID_W(PID_W), .PMG_W(PMG_W), .LEN_W(LEN_W), .MON_W(MON_W)
        ) i_mon (
            .clk(clk), .rst(rst),
            .prog(mon_clr[m]),
            .prog_pid(cfg_wdata[PID_W-1:0]),
            .prog_pmg(cfg_wdata[PID_W +: PMG_W]),
            .prog_dir(cfg_wdata[PID_W+PMG_W]),
            .fire(fire), .pid(out_pid), .pmg(out_pmg), .dir(out_write), .len(out_len),
            .count(mon_count[m*MON_W +: MON_W])
        );
    end

endmodule

// File: rtl/bwr_chk.sv
module bwr_chk #(
    parameter int NSRC   = 3,
    parameter int MON_W  = 32,
    parameter int CRED_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   src_valid,
    input logic [NSRC-1:0]   src_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [NSRC-1:0]   urgent,
    input logic [NSRC-1:0]   grant,
    input logic              mon0_clr,
    input logic [MON_W-1:0]  mon0,
    input logic [CRED_W-1:0] cred0,
    input logic [CRED_W-2:0] refill0
);
    // R10
    single_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_ready));

    // R10
    accept_needs_offer_chk: assert property (@(posedge clk) disable iff (rst)
        (|src_ready) |-> (out_ready && out_valid && (src_ready & ~src_valid) == '0));

    // R2
    idle_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (src_ready == '0));

    // R5
    urgent_first_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (|urgent)) |-> (|(grant & urgent)));

    // R3
    credit_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cred0 <= {refill0, 1'b0});

    // R8
    mon_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !mon0_clr |=> (mon0 >= $past(mon0)));

endmodule

bind part_bw_regulator bwr_chk #(
    .NSRC(NSRC), .MON_W(MON_W), .CRED_W(CRED_W)
) i_bwr_chk (
    .clk(clk), .rst(rst),
    .src_valid(src_valid), .src_ready(src_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .urgent(arb_urgent), .grant(arb_grant),
    .mon0_clr(mon_clr[0]), .mon0(mon_count[MON_W-1:0]),
    .cred0(bank_cred[0]), .refill0(bank_refill[0])
);

// File: tb/test_part_bw_regulator.sv
module test_part_bw_regulator;
    localparam int NSRC = 3, PID_W = 2, PMG_W = 2, LEN_W = 8, ADDR_W = 16;
    localparam int CRED_W = 12, PERIOD = 256, NUM_MON = 2, MON_W = 8, CFG_AW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NSRC-1:0]         src_valid = '0, src_tagged = '0, src_write = '0;
    logic [NSRC-1:0]         src_ready;
    logic [NSRC*PID_W-1:0]   src_pid = '0;
    logic [NSRC*PMG_W-1:0]   src_pmg = '0;
    logic [NSRC*LEN_W-1:0]   src_len = '0;
    logic [NSRC*ADDR_W-1:0]  src_addr = '0;
    logic out_valid, out_write;
    logic out_ready = 1'b1;
    logic [PID_W-1:0]  out_pid;
    logic [PMG_W-1:0]  out_pmg;
    logic [LEN_W-1:0]  out_len;
    logic [ADDR_W-1:0] out_addr;
    logic cfg_we = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [CRED_W-2:0] cfg_wdata = '0;
    logic [NUM_MON*MON_W-1:0] mon_count;

    int n_chk = 0;
    int n_bad = 0;
    int cyc;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    part_bw_regulator #(
        .NSRC(NSRC), .PID_W(PID_W), .PMG_W(PMG_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W),
        .CRED_W(CRED_W), .PERIOD(PERIOD), .NUM_MON(NUM_MON), .MON_W(MON_W)
    ) i_part_bw_regulator (
        .clk(clk), .rst(rst),
        .src_valid(src_valid), .src_ready(src_ready), .src_tagged(src_tagged),
        .src_pid(src_pid), .src_pmg(src_pmg), .src_write(src_write),
        .src_len(src_len), .src_addr(src_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_pid(out_pid),
        .out_pmg(out_pmg), .out_write(out_write), .out_len(out_len), .out_addr(out_addr),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mon_count(mon_count)
    );

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic clr_src();
        src_valid = '0; src_tagged = '0; src_write = '0;
        src_pid = '0; src_pmg = '0; src_len = '0; src_addr = '0;
    endtask

    task automatic set_src(input int s, input bit tg, input int pid, input int pmg,
                           input bit wr, input int len);
        src_valid[s] = 1'b1;
        src_tagged[s] = tg;
        src_write[s] = wr;
        src_pid[s*PID_W +: PID_W] = PID_W'(pid);
        src_pmg[s*PMG_W +: PMG_W] = PMG_W'(pmg);
        src_len[s*LEN_W +: LEN_W] = LEN_W'(len);
        src_addr[s*ADDR_W +: ADDR_W] = ADDR_W'(16'hA000 + len);
    endtask

    // one cycle: offer a single request and check whether it issues
    task automatic try1(input int s, input bit tg, input int pid, input int pmg, input bit wr,
                        input int len, input bit rdy, input bit exp, input string r);
        @(negedge clk);
        clr_src();
        out_ready = rdy;
        set_src(s, tg, pid, pmg, wr, len);
        #2;
        chk(r, out_valid, exp);
        chk(r, src_ready[s], exp && rdy);
    endtask

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        clr_src();
        cfg_we = 1'b1; cfg_addr = CFG_AW'(a); cfg_wdata = (CRED_W-1)'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // returns just after a refill edge, leaving a full period ahead
    task automatic wait_fresh();
        @(negedge clk);
        clr_src();
        while (cyc % PERIOD != 0) @(negedge clk);
    endtask

    task automatic t_reset();
        try1(0, 1, 0, 0, 0, 1, 1'b1, 1'b0, "R1 no credit after reset");
        chk("R1 monitor 0 zero", mon_count[0 +: MON_W], 0);
        chk("R1 monitor 1 zero", mon_count[MON_W +: MON_W], 0);
    endtask

    task automatic t_budget();
        wait_fresh();
        cfg_write(0, 100);
        try1(0, 1, 0, 0, 0, 64, 1'b1, 1'b1, "R2 within credit");
        try1(0, 1, 0, 0, 0, 64, 1'b1, 1'b0, "R2 beyond credit");
        try1(0, 1, 0, 0, 0, 36, 1'b1, 1'b1, "R2 exact credit");
        try1(0, 1, 0, 0, 0, 1, 1'b1, 1'b0, "R11 held when empty");
        wait_fresh();
        try1(0, 1, 0, 0, 0, 100, 1'b1, 1'b1, "R11 issues after refill");
        try1(0, 1, 0, 0, 0, 1, 1'b1, 1'b0, "R11 empty again");
    endtask

    task automatic t_sat();
        wait_fresh();
        cfg_write(2, 100);
        wait_fresh(); wait_fresh(); wait_fresh();
        try1(0, 1, 1, 0, 0, 201, 1'b1, 1'b0, "R3 above cap");
        try1(0, 1, 1, 0, 0, 200, 1'b1, 1'b1, "R3 at cap");
        try1(0, 1, 1, 0, 0, 1, 1'b1, 1'b0, "R3 drained");
    endtask

    task automatic t_dir();
        wait_fresh();
        cfg_write(4, 10);
        cfg_write(5, 50);
        try1(1, 1, 2, 0, 0, 20, 1'b1, 1'b0, "R4 read short");
        try1(1, 1, 2, 0, 1, 20, 1'b1, 1'b1, "R4 write independent");
        try1(1, 1, 2, 0, 0, 10, 1'b1, 1'b1, "R4 read untouched");
    endtask

    task automatic t_prio();
        wait_fresh();
        cfg_write(0, 200);
        cfg_write(2, 200);
        cfg_write(10, 50);
        @(negedge clk);
        clr_src();
        out_ready = 1'b1;
        set_src(0, 1, 0, 0, 0, 30);
        set_src(1, 1, 1, 0, 0, 30);
        #2;
        chk("R5 urgent wins", src_ready, 3'b010);
        chk("R5 urgent pid", out_pid, 1);
        @(negedge clk);
        #2;
        chk("R5 still below min", src_ready, 3'b010);
        @(negedge clk);
        #2;
        chk("R5 min met, lowest index", src_ready, 3'b001);
        chk("R5 pid after min", out_pid, 0);
    endtask

    task automatic t_default();
        cfg_write(24, 11);
        cfg_write(7, 100);
        try1(2, 0, 0, 0, 1, 8, 1'b1, 1'b1, "R6 untagged issues");
        chk("R6 default pid", out_pid, 3);
        chk("R6 default group", out_pmg, 2);
        chk("R6 address", out_addr, 16'hA008);
    endtask

    task automatic t_mon();
        cfg_write(16, 4);
        cfg_write(17, 20);
        cfg_write(0, 250);
        cfg_write(1, 250);
        try1(0, 1, 0, 1, 0, 40, 1'b1, 1'b1, "R7 matching read");
        try1(0, 1, 0, 2, 0, 30, 1'b1, 1'b1, "R7 other group");
        try1(0, 1, 0, 1, 1, 7, 1'b1, 1'b1, "R7 matching write");
        @(negedge clk);
        clr_src();
        #2;
        chk("R7 read monitor", mon_count[0 +: MON_W], 40);
        chk("R7 write monitor", mon_count[MON_W +: MON_W], 7);
        cfg_write(16, 4);
        #2;
        chk("R9 cleared", mon_count[0 +: MON_W], 0);
        chk("R9 other kept", mon_count[MON_W +: MON_W], 7);
        cfg_write(0, 600);
        try1(0, 1, 0, 1, 0, 200, 1'b1, 1'b1, "R8 first");
        try1(0, 1, 0, 1, 0, 200, 1'b1, 1'b1, "R8 second");
        @(negedge clk);
        clr_src();
        #2;
        chk("R8 saturated", mon_count[0 +: MON_W], 255);
    endtask

    task automatic t_stall();
        wait_fresh();
        cfg_write(3, 100);
        try1(1, 1, 1, 0, 1, 60, 1'b0, 1'b1, "R10 stall 1");
        try1(1, 1, 1, 0, 1, 60, 1'b0, 1'b1, "R10 stall 2");
        try1(1, 1, 1, 0, 1, 60, 1'b0, 1'b1, "R10 stall 3");
        try1(1, 1, 1, 0, 1, 60, 1'b1, 1'b1, "R10 accepted");
        try1(1, 1, 1, 0, 1, 40, 1'b1, 1'b1, "R10 credit spent once");
        try1(1, 1, 1, 0, 1, 1, 1'b1, 1'b0, "R10 credit now empty");
        @(negedge clk);
        clr_src();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_budget();
        t_sat();
        t_dir();
        t_prio();
        t_default();
        t_mon();
        t_stall();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule